// File: doc/BRIEF.md
# Receive Page Formatter

This block writes one incoming Ethernet frame into a 2048-byte page of packet memory, using the layout that the receive side of the controller expects. A frame begins with a start request that carries the frame length and the number of a page that the allocator has already granted. The block first writes a four-byte header: a status word, then the stored byte count. After that come the frame bytes, zero padding for short frames, an optional CRC-32, and a closing two-byte word. That closing word tells whether the frame had an odd length and, for long odd frames, carries the last byte. All of these go out as byte writes, one per clock. A single-cycle done pulse then serves as the set request for the receive interrupt bit.

When receive is disabled, when soft reset is held, or when the laid-out page would need more than 2048 bytes, the block refuses the frame. In that case it gives a one-cycle reject pulse and writes nothing. The frame bytes come in on a valid/ready byte stream. `s_ready` is high only while the block is taking frame data. The source may drop `s_valid` for any number of cycles, and nothing advances until a byte is transferred. The source must not present the bytes of a frame that was refused. The start request is a valid/ready pair as well. `start_ready` is high only while the block is idle. The configuration inputs are sampled when a start is accepted.

Top module: `rx_page_formatter`

## Requirements
- R1: A start accepted while `cfg_rx_en` is 0 or `cfg_soft_rst` is 1 produces one `reject_o` pulse in the next cycle, no buffer write and no done pulse.
- R2: The stored count is computed as follows. Take 64 for frames shorter than 64 bytes, or the length with bit 0 cleared otherwise. Add 6, then add a further 4 when `cfg_strip_crc` is 0. If the result exceeds 2048, the frame is rejected as in R1.
- R3: Page offsets 2 and 3 hold the stored count of R2, with the low byte at offset 2.
- R4: Offsets 0 and 1 hold a status word, with the low byte at offset 0. Bit 11 is set when the length exceeds 1518, bit 12 is set when the length is odd, and every other bit is 0.
- R5: Every write address is `{page, offset}`, with the offset in the low 11 bits. Frame bytes are stored in order starting at offset 4.
- R6: For a frame shorter than 64 bytes, every received byte, including an odd last one, is stored directly. Zero bytes follow until 64 data bytes are stored.
- R7: When `cfg_strip_crc` is 0, the data bytes are followed by a CRC-32, least significant byte first. The CRC uses the reflected polynomial 0xEDB88320, starts from all ones, is inverted at the end, and is computed over the padded data. For a long odd frame it also covers the last byte, although that byte is stored only after the CRC.
- R8: The last two bytes of the page image are the held last byte followed by 0x60 for an odd frame of 64 or more bytes. For every other frame they are 0x00 followed by 0x40.
- R9: Consecutive write cycles use consecutive offsets within one page. `done_o` pulses once, in the cycle right after the last write.
- R10: `s_ready` is 1 only during the data phase, and bytes offered at any other time are not taken. Changes to the configuration inputs after a start is accepted do not affect that frame.
- R11: `start_ready` is 1 exactly when the block is idle and not writing. After reset, `start_ready` is 1 and all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_soft_rst | input | 1 | Soft reset held; refuses frames |
| cfg_strip_crc | input | 1 | 1 drops the CRC from the page image |
| start_valid | input | 1 | Start request for a new frame |
| start_ready | output | 1 | Block is idle and takes a start |
| start_len | input | LEN_W | Frame length in bytes |
| start_page | input | PG_W | Granted page number |
| s_valid | input | 1 | Frame byte valid |
| s_ready | output | 1 | Frame byte taken this cycle if valid |
| s_data | input | 8 | Frame byte |
| wr_en | output | 1 | Buffer byte write strobe |
| wr_addr | output | PG_W+11 | Buffer byte address {page, offset} |
| wr_data | output | 8 | Buffer byte value |
| done_o | output | 1 | Frame stored; set receive interrupt |
| reject_o | output | 1 | Frame refused |

## Verification
Two events can fall in the same cycle. In the first, the last data byte arrives in the same transfer that switches the block to padding, CRC or the tail. This is provoked by frames of length 63, 64 and 65, frames with odd and even lengths, and random stalls placed just before the last byte. The page image must still show no gap and no repeated offset. In the second, a configuration change lands on the cycle after a start is accepted. The bench flips the CRC-strip input during frames and judges the written image against the value that was sampled at start. Back-to-back starts check that a new request waits until the done cycle has passed.

// File: rtl/rxfmt_pkg.sv
package rxfmt_pkg;
  localparam int OFF_W      = 11;
  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int MIN_DATA   = 64;
  localparam int MAX_STD    = 1518;
  localparam int HDR_BYTES  = 4;
  localparam int CRC_BYTES  = 4;
  localparam int TAIL_BYTES = 2;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [7:0]  TAIL_ODD  = 8'h60;
  localparam logic [7:0]  TAIL_EVEN = 8'h40;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_DATA, S_PAD, S_CRC, S_TAIL, S_DONE
  } fmt_state_e;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int b = 0; b < 8; b++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/rxfmt_hdr.sv
module rxfmt_hdr
  import rxfmt_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic [LEN_W-1:0] frame_len,
  input  logic             strip_crc,
  output logic [15:0]      status_word,
  output logic [15:0]      stored_len,
  output logic             too_big,
  output logic             is_odd,
  output logic             is_short
);
  localparam int SW = LEN_W + 1;

  logic [SW-1:0] base;
  logic [SW-1:0] total;

  always_comb begin
    is_odd   = frame_len[0];
    is_short = frame_len < LEN_W'(MIN_DATA);
    base     = is_short ? SW'(MIN_DATA) : SW'({frame_len[LEN_W-1:1], 1'b0});
    total    = base + SW'(HDR_BYTES + TAIL_BYTES) + (strip_crc ? SW'(0) : SW'(CRC_BYTES));
    too_big  = total > SW'(PAGE_BYTES);
    stored_len = 16'(total);
    status_word      = '0;
    status_word[12]  = is_odd;
    status_word[11]  = frame_len > LEN_W'(MAX_STD);
  end
endmodule

// File: rtl/rxfmt_crc32.sv
module rxfmt_crc32
  import rxfmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_o
);
  logic [31:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '1;
    else if (clr) acc_q <= '1;
    else if (en)  acc_q <= crc_step(acc_q, din);
  end

  assign crc_o = ~acc_q;
endmodule

// File: rtl/rx_page_formatter.sv
module rx_page_formatter
  import rxfmt_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int PG_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_rx_en,
  input  logic                  cfg_soft_rst,
  input  logic                  cfg_strip_crc,
  input  logic                  start_valid,
  output logic                  start_ready,
  input  logic [LEN_W-1:0]      start_len,
  input  logic [PG_W-1:0]       start_page,
  input  logic                  s_valid,
  output logic                  s_ready,
  input  logic [7:0]            s_data,
  output logic                  wr_en,
  output logic [PG_W+OFF_W-1:0] wr_addr,
  output logic [7:0]            wr_data,
  output logic                  done_o,
  output logic                  reject_o
);
  localparam logic [OFF_W-1:0] PAD_LAST = OFF_W'(HDR_BYTES + MIN_DATA - 1);

  fmt_state_e        state_q;
  logic [OFF_W-1:0]  off_q;
  logic [LEN_W-1:0]  idx_q, len_q;
  logic [1:0]        k_q;
  logic [PG_W-1:0]   page_q;
  logic              keep_q, short_q, long_odd_q, reject_q;
  logic [7:0]        held_q;
  logic [15:0]       stat_q, slen_q;

  logic [15:0] h_status, h_slen;
  logic        h_big, h_odd, h_short;
  logic [31:0] crc_val;
  logic        accept, refuse, take, hold_cyc, last_byte;
  logic        crc_en;
  logic [7:0]  crc_din;

  rxfmt_hdr #(.LEN_W(LEN_W)) u_hdr (
    .frame_len  (start_len),
    .strip_crc  (cfg_strip_crc),
    .status_word(h_status),
    .stored_len (h_slen),
    .too_big    (h_big),
    .is_odd     (h_odd),
    .is_short   (h_short)
  );

  assign refuse    = !cfg_rx_en || cfg_soft_rst || h_big;
  assign accept    = (state_q == S_IDLE) && start_valid && !refuse;
  assign take      = (state_q == S_DATA) && s_valid;
  assign last_byte = idx_q == (len_q - LEN_W'(1));
  assign hold_cyc  = long_odd_q && last_byte;
  assign crc_en    = take || (state_q == S_PAD);
  assign crc_din   = (state_q == S_PAD) ? 8'h00 : s_data;

  rxfmt_crc32 u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (accept),
    .en   (crc_en),
    .din  (crc_din),
    .crc_o(crc_val)
  );

  always_comb begin
    start_ready = state_q == S_IDLE;
    s_ready     = state_q == S_DATA;
    done_o      = state_q == S_DONE;
    reject_o    = reject_q;
    wr_addr     = {page_q, off_q};
    wr_en       = 1'b0;
    wr_data     = 8'h00;
    unique case (state_q)
      S_HDR: begin
        wr_en = 1'b1;
        unique case (k_q)
          2'd0: wr_data = stat_q[7:0];
          2'd1: wr_data = stat_q[15:8];
          2'd2: wr_data = slen_q[7:0];
          default: wr_data = slen_q[15:8];
        endcase
      end
      S_DATA: begin
        wr_en   = take && !hold_cyc;
        wr_data = s_data;
      end
      S_PAD: wr_en = 1'b1;
      S_CRC: begin
        wr_en   = 1'b1;
        wr_data = crc_val[8*k_q +: 8];
      end
      S_TAIL: begin
        wr_en = 1'b1;
        if (k_q == 2'd0) wr_data = long_odd_q ? held_q : 8'h00;
        else             wr_data = long_odd_q ? TAIL_ODD : TAIL_EVEN;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      off_q      <= '0;
      idx_q      <= '0;
      len_q      <= '0;
      k_q        <= '0;
      page_q     <= '0;
      keep_q     <= 1'b0;
      short_q    <= 1'b0;
      long_odd_q <= 1'b0;
      reject_q   <= 1'b0;
      held_q     <= '0;
      stat_q     <= '0;
      slen_q     <= '0;
    end else begin
      reject_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start_valid && refuse) begin
            reject_q <= 1'b1;
          end else if (accept) begin
            state_q    <= S_HDR;
            off_q      <= '0;
            idx_q      <= '0;
            k_q        <= '0;
            len_q      <= start_len;
            page_q     <= start_page;
            keep_q     <= !cfg_strip_crc;
            short_q    <= h_short;
            long_odd_q <= h_odd && !h_short;
            stat_q     <= h_status;
            slen_q     <= h_slen;
          end
        end
        S_HDR: begin
          off_q <= off_q + 1'b1;
          k_q   <= k_q + 1'b1;
          if (k_q == 2'd3) state_q <= (len_q == '0) ? S_PAD : S_DATA;
        end
        S_DATA: begin
          if (s_valid) begin
            idx_q <= idx_q + 1'b1;
            if (hold_cyc) held_q <= s_data;
            else          off_q  <= off_q + 1'b1;
            if (last_byte) begin
              if (short_q)     state_q <= S_PAD;
              else if (keep_q) state_q <= S_CRC;
              else             state_q <= S_TAIL;
            end
          end
        end
        S_PAD: begin
          off_q <= off_q + 1'b1;
          if (off_q == PAD_LAST) state_q <= keep_q ? S_CRC : S_TAIL;
        end
        S_CRC: begin
          off_q <= off_q + 1'b1;
          k_q   <= k_q + 1'b1;
          if (k_q == 2'd3) state_q <= S_TAIL;
        end
        S_TAIL: begin
          off_q <= off_q + 1'b1;
          k_q   <= k_q + 1'b1;
          if (k_q == 2'd1) state_q <= S_DONE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxfmt_chk.sv
module rxfmt_chk #(
  parameter int PG_W  = 2,
  parameter int OFF_W = 11
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_valid,
  input logic                  start_ready,
  input logic                  s_ready,
  input logic                  wr_en,
  input logic [PG_W+OFF_W-1:0] wr_addr,
  input logic                  done_o,
  input logic                  reject_o
);
  // R11: no write while the block offers to take a start
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !start_ready);

  // R10: stream accepted only while a frame is in flight
  a_r10_stream_busy: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !start_ready);

  // R9: done follows a write cycle directly
  a_r9_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(wr_en) && !wr_en));

  // R9: back-to-back writes step the offset by one
  a_r9_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr[OFF_W-1:0] == $past(wr_addr[OFF_W-1:0]) + 1'b1));

  // R5: one page per frame
  a_r5_page_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> $stable(wr_addr[PG_W+OFF_W-1:OFF_W]));

  // R1: a refusal follows a start request and is silent
  a_r1_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    reject_o |-> (!wr_en && !done_o && $past(start_valid && start_ready)));
endmodule

bind rx_page_formatter rxfmt_chk #(.PG_W(PG_W), .OFF_W(rxfmt_pkg::OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
  .s_ready(s_ready), .wr_en(wr_en), .wr_addr(wr_addr), .done_o(done_o),
  .reject_o(reject_o)
);

// File: tb/sim_rx_page_formatter.sv
`timescale 1ns/1ps
module sim_rx_page_formatter;
  localparam int LEN_W = 12;
  localparam int PG_W  = 2;
  localparam int AW    = PG_W + 11;

  logic clk = 0, rst_n = 0;
  logic cfg_rx_en = 0, cfg_soft_rst = 0, cfg_strip_crc = 0;
  logic start_valid = 0, start_ready;
  logic [LEN_W-1:0] start_len = '0;
  logic [PG_W-1:0]  start_page = '0;
  logic s_valid = 0, s_ready;
  logic [7:0] s_data = '0;
  logic wr_en, done_o, reject_o;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;

  always #2.5 clk = ~clk;

  rx_page_formatter #(.LEN_W(LEN_W), .PG_W(PG_W)) u0 (.*);

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] fb [0:4095];
  logic [7:0] exp_b [0:2200];
  int exp_n;
  int log_off [0:2200];
  int log_pg  [0:2200];
  logic [7:0] log_dat [0:2200];
  int log_n, done_cnt, rej_cnt, timing_err, busy_err, sready_seen;
  logic prev_wr = 0;

  always @(posedge clk) cycles++;

  always @(negedge clk) if (rst_n) begin
    if (wr_en && log_n <= 2200) begin
      log_off[log_n] = int'(wr_addr[10:0]);
      log_pg[log_n]  = int'(wr_addr[AW-1:11]);
      log_dat[log_n] = wr_data;
      log_n++;
      if (start_ready) busy_err++;
    end
    if (done_o) begin
      done_cnt++;
      if (!prev_wr) timing_err++;
    end
    if (reject_o) rej_cnt++;
    if (s_ready) sready_seen++;
    prev_wr = wr_en;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int stored_of(input int len, input bit strip);
    int b;
    b = (len < 64) ? 64 : (len & ~1);
    return b + 6 + (strip ? 0 : 4);
  endfunction

  function automatic void build_exp(input int len, input bit keep);
    int n, dl, st;
    logic [31:0] c;
    logic [7:0] by;
    bit odd, short_f;
    odd = len[0]; short_f = len < 64;
    st = (len > 1518 ? 32'h0800 : 0) | (odd ? 32'h1000 : 0);
    n = 0;
    exp_b[n++] = st[7:0]; exp_b[n++] = st[15:8];
    exp_b[n++] = 8'(stored_of(len, !keep)); exp_b[n++] = 8'(stored_of(len, !keep) >> 8);
    for (int i = 0; i < (len & ~1); i++) exp_b[n++] = fb[i];
    if (short_f) begin
      if (odd) exp_b[n++] = fb[len-1];
      for (int i = len; i < 64; i++) exp_b[n++] = 8'h00;
    end
    dl = short_f ? 64 : len;
    if (keep) begin
      c = 32'hFFFFFFFF;
      for (int i = 0; i < dl; i++) begin
        by = (i < len) ? fb[i] : 8'h00;
        for (int b = 0; b < 8; b++) begin
          if (c[0] ^ by[b]) c = (c >> 1) ^ 32'hEDB88320;
          else              c = c >> 1;
        end
      end
      c = ~c;
      for (int b = 0; b < 4; b++) exp_b[n++] = c[8*b +: 8];
    end
    if (!short_f && odd) begin exp_b[n++] = fb[len-1]; exp_b[n++] = 8'h60; end
    else                 begin exp_b[n++] = 8'h00;     exp_b[n++] = 8'h40; end
    exp_n = n;
  endfunction

  function automatic int first_bad(input int a, input int b, input int pg);
    for (int i = a; i < b; i++)
      if (i >= log_n || log_off[i] != i || log_pg[i] != pg || log_dat[i] !== exp_b[i]) return i;
    return -1;
  endfunction

  task automatic run_frame(input int len, input bit rxen, input bit srst, input bit strip,
                           input bit stall, input int pg, input bit flip);
    bit exp_rej;
    int bad, dl, t;
    for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
    log_n = 0; done_cnt = 0; rej_cnt = 0; timing_err = 0; busy_err = 0;
    @(posedge clk); #1;
    cfg_rx_en = rxen; cfg_soft_rst = srst; cfg_strip_crc = strip;
    start_len = LEN_W'(len); start_page = PG_W'(pg); start_valid = 1;
    forever begin
      @(negedge clk);
      if (start_ready) break;
    end
    @(posedge clk); #1;
    start_valid = 0;
    if (flip) cfg_strip_crc = !strip;
    exp_rej = !rxen || srst || stored_of(len, strip) > 2048;
    if (exp_rej) begin
      repeat (4) @(posedge clk);
      #1;
      chk(rej_cnt == 1 && log_n == 0 && done_cnt == 0, (!rxen || srst) ? "R1 refuse" : "R2 oversize",
          rej_cnt * 10000 + log_n, 1 * 10000);
      return;
    end
    for (int i = 0; i < len; i++) begin
      if (stall && ($urandom % 4 == 0)) begin
        s_valid = 0; @(posedge clk); #1;
      end
      s_valid = 1; s_data = fb[i];
      forever begin
        @(negedge clk);
        if (s_ready) break;
      end
      @(posedge clk); #1;
    end
    s_valid = 0;
    t = 0;
    while (done_cnt == 0 && t < 6000) begin @(posedge clk); t++; end
    repeat (2) @(posedge clk);
    #1;
    build_exp(len, !strip);
    dl = (len < 64) ? 64 : len;
    chk(log_n == exp_n, "R2 image size", log_n, exp_n);
    bad = first_bad(0, 4, pg);
    chk(bad < 0, "R3/R4 header", bad < 0 ? 0 : int'(log_dat[bad]), bad < 0 ? 0 : int'(exp_b[bad]));
    bad = first_bad(4, 4 + (dl & ~1) + ((len < 64) ? 0 : 0), pg);
    chk(bad < 0, "R5/R6 data", bad, -1);
    if (len < 64) begin
      bad = first_bad(4, 68, pg);
      chk(bad < 0, "R6 pad", bad, -1);
    end
    if (!strip) begin
      bad = first_bad(exp_n - 6, exp_n - 2, pg);
      chk(bad < 0, "R7 crc", bad < 0 ? 0 : int'(log_dat[bad]), bad < 0 ? 0 : int'(exp_b[bad]));
    end
    bad = first_bad(exp_n - 2, exp_n, pg);
    chk(bad < 0, "R8 tail", bad < 0 ? 0 : int'(log_dat[bad]), bad < 0 ? 0 : int'(exp_b[bad]));
    chk(done_cnt == 1 && timing_err == 0 && rej_cnt == 0, "R9 done", done_cnt * 10 + timing_err, 10);
    chk(busy_err == 0, "R11 busy", busy_err, 0);
    if (flip) chk(log_n == exp_n, "R10 config latched", log_n, exp_n);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(start_ready && !wr_en && !done_o && !reject_o && !s_ready, "R11 reset",
        {start_ready, wr_en, done_o, reject_o, s_ready}, 5'b10000);
    // R10 stray stream bytes while idle
    log_n = 0; sready_seen = 0;
    @(posedge clk); #1 s_valid = 1; s_data = 8'hA5;
    repeat (4) @(posedge clk);
    #1 s_valid = 0;
    chk(log_n == 0 && sready_seen == 0, "R10 idle stream", log_n + sready_seen, 0);
    // directed corners
    run_frame(60, 0, 0, 0, 0, 1, 0);      // R1 disabled
    run_frame(60, 1, 1, 0, 0, 1, 0);      // R1 soft reset
    run_frame(2040, 1, 0, 0, 0, 2, 0);    // R2 too big with crc
    run_frame(2044, 1, 0, 1, 0, 2, 0);    // R2 too big stripped
    run_frame(2039, 1, 0, 0, 0, 3, 0);    // R2 exactly 2048
    run_frame(2043, 1, 0, 1, 0, 0, 0);    // R2 exactly 2048 stripped
    run_frame(0, 1, 0, 0, 0, 1, 0);       // R6 empty
    run_frame(1, 1, 0, 0, 1, 2, 0);       // R6 single odd
    run_frame(63, 1, 0, 0, 1, 3, 0);      // R6 short odd
    run_frame(64, 1, 0, 0, 1, 0, 0);      // boundary even
    run_frame(65, 1, 0, 0, 1, 1, 0);      // R8 long odd
    run_frame(65, 1, 0, 1, 0, 1, 1);      // R10 flip strip
    run_frame(1518, 1, 0, 0, 0, 2, 0);    // R4 limit
    run_frame(1519, 1, 0, 1, 1, 3, 1);    // R4 over limit
    for (int f = 0; f < 30; f++) begin
      int len;
      len = (f % 3 == 0) ? int'($urandom % 70) : int'($urandom % 1600);
      run_frame(len, ($urandom % 8) != 0, ($urandom % 10) == 0, $urandom % 2,
                $urandom % 2, int'($urandom % 4), ($urandom % 4) == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule